// File: doc/BRIEF.md
# Address-Masked GPIO Port with Per-Pin Interrupt Detection

This block is an eight-pin general purpose I/O port on a 32-bit APB-style register bus. Every pin has a direction bit and a stored output value. Through the data window, address bits [9:2] act as a bit mask. Software can therefore set or read any subset of pins with one access, with no read-modify-write. Input pins pass through a two-flop synchronizer before software or the interrupt logic sees them.

Each pin has its own interrupt detector. It can be set for:
- a high level or a low level;
- a rising edge or a falling edge;
- both edges.

Edge events latch into raw status until software acknowledges them with a write-one-to-clear. Level conditions follow the synchronized pin live. Raw status is gated by an enable register, and the results are ORed onto one interrupt line.

Top module: `mgpio_top`

## Requirements
- R1: After reset, all register bits are zero: direction, output data, sense, both-edges, event, enable and latched status. So `pin_oe_o` = 0, `irq_o` = 0, and every register reads 0 while the inputs are low.
- R2: The direction register at 0x400 makes pin k an output when bit k = 1. `pin_oe_o[k]` equals that bit, `pin_o` carries the stored output values, and the register reads back what was written.
- R3: A write to any offset from 0x000 to 0x3FC updates output bit k only when address bit k+2 is 1. All other stored bits keep their value.
- R4: A read from the data window returns 0 in bit k when address bit k+2 is 0. Otherwise it returns the stored output value for an output pin, or the synchronized input for an input pin.
- R5: A data write leaves the stored value of an input pin unchanged. That pin still drives its old value after it is switched to output.
- R6: `pin_i` passes through two flops. A pin change is visible in data reads and to the interrupt logic after two rising clock edges.
- R7: With sense bit k = 1 (0x404), pin k is in level mode. Event bit k (0x40C) = 1 means active high and 0 means active low. Raw status bit k follows the synchronized level, and a clear write does not remove it while the level persists.
- R8: With sense bit k = 0 and both-edges bit k = 0, pin k latches raw status on a rising edge if event bit k = 1, or on a falling edge if it is 0. The opposite edge sets nothing.
- R9: With sense bit k = 0 and both-edges bit k (0x408) = 1, pin k latches raw status on either edge, whatever the event bit holds.
- R10: Raw status reads at 0x414. Masked status at 0x418 equals raw status ANDed with the enable register at 0x410.
- R11: Writing 1 to bit k at 0x41C clears the latched edge status of pin k. Writing 0 leaves it unchanged.
- R12: `irq_o` is 1 exactly when some masked status bit is 1.
- R13: The clear register and unmapped offsets (0x420 and above) read as 0. Writes to the status registers or to unmapped offsets change no state, and reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Bus select |
| penable_i | input | 1 | Bus access phase |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 12 | Byte address |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, bits [31:8] zero |
| pin_i | input | 8 | Pin input levels |
| pin_o | output | 8 | Stored output values |
| pin_oe_o | output | 8 | Output enable per pin (direction) |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench covers the following corner cases, with the fault that each one would expose:
- **Masked data access.** One-hot and mixed address masks are used on writes and reads. A design that ignored the mask would overwrite neighbouring pins or leak unmasked bits into the read data.
- **Writes to input pins.** A data write is aimed at pins set as inputs, and then those pins are turned into outputs. A design that stored the value anyway would drive a value that was never intended.
- **Level sources.** Clear writes are issued while a level condition holds. A design that latched level status would stay asserted after the pin returns to its inactive level.
- **Edge and both-edge modes.** Each mode gets both transitions. A design with the polarity inverted, or one that checked the event bit in both-edge mode, would latch on the wrong edge.
- **Clear writes.** Zero-valued clear writes are checked. A design that cleared on 0 would drop pending events.
- **Status decode.** Writes to status registers and to unmapped offsets are checked. A design with a loose decode would corrupt configuration.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_DIR   = 12'h400;
  localparam logic [ADDR_W-1:0] OFF_SENSE = 12'h404;
  localparam logic [ADDR_W-1:0] OFF_BOTH  = 12'h408;
  localparam logic [ADDR_W-1:0] OFF_EVT   = 12'h40C;
  localparam logic [ADDR_W-1:0] OFF_IE    = 12'h410;
  localparam logic [ADDR_W-1:0] OFF_RIS   = 12'h414;
  localparam logic [ADDR_W-1:0] OFF_MIS   = 12'h418;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 12'h41C;
endpackage

// File: rtl/mgpio_sync.sv
module mgpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/mgpio_irq.sv
module mgpio_irq #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PINS-1:0] lvl_i,
  input  logic [PINS-1:0] sense_i,
  input  logic [PINS-1:0] both_i,
  input  logic [PINS-1:0] evt_i,
  input  logic [PINS-1:0] clr_i,
  output logic [PINS-1:0] raw_o
);
  for (genvar g = 0; g < PINS; g++) begin : g_pin
    logic prev_q, latch_q, rise, fall, edge_hit, lvl_hit;

    assign rise     = lvl_i[g] & ~prev_q;
    assign fall     = ~lvl_i[g] & prev_q;
    assign edge_hit = ~sense_i[g] &
                      (both_i[g] ? (rise | fall) : (evt_i[g] ? rise : fall));
    assign lvl_hit  = evt_i[g] ? lvl_i[g] : ~lvl_i[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q  <= 1'b0;
        latch_q <= 1'b0;
      end else begin
        prev_q <= lvl_i[g];
        // a new edge wins over a same-cycle clear
        if (edge_hit)      latch_q <= 1'b1;
        else if (clr_i[g]) latch_q <= 1'b0;
      end
    end

    assign raw_o[g] = sense_i[g] ? lvl_hit : latch_q;

    assert_edge_latch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_hit |=> latch_q);
    assert_w1c_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (latch_q && clr_i[g] && !edge_hit) |=> !latch_q);
    assert_latch_keep_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (latch_q && !clr_i[g]) |=> latch_q);
  end
endmodule

// File: rtl/mgpio_regs.sv
module mgpio_regs
  import mgpio_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [BUS_W-1:0]  pwdata_i,
  output logic [BUS_W-1:0]  prdata_o,
  input  logic [PINS-1:0]   din_i,
  input  logic [PINS-1:0]   raw_i,
  output logic [PINS-1:0]   dir_o,
  output logic [PINS-1:0]   data_o,
  output logic [PINS-1:0]   sense_o,
  output logic [PINS-1:0]   both_o,
  output logic [PINS-1:0]   evt_o,
  output logic [PINS-1:0]   mis_o,
  output logic [PINS-1:0]   clr_o
);
  localparam int unsigned WIN_LSB = PINS + 2;

  logic              wr_en, data_win;
  logic [ADDR_W-1:0] addr_w;
  logic [PINS-1:0]   mask, wdat, rd;
  logic [PINS-1:0]   dir_q, data_q, sense_q, both_q, evt_q, ie_q;

  assign wr_en    = psel_i & penable_i & pwrite_i;
  assign data_win = (paddr_i[ADDR_W-1:WIN_LSB] == '0);
  assign addr_w   = {paddr_i[ADDR_W-1:2], 2'b00};
  assign mask     = paddr_i[WIN_LSB-1:2];
  assign wdat     = pwdata_i[PINS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      data_q  <= '0;
      sense_q <= '0;
      both_q  <= '0;
      evt_q   <= '0;
      ie_q    <= '0;
    end else if (wr_en) begin
      if (data_win) begin
        // only masked bits of output pins take the new value
        data_q <= (data_q & ~(mask & dir_q)) | (wdat & mask & dir_q);
      end else begin
        unique case (addr_w)
          OFF_DIR:   dir_q   <= wdat;
          OFF_SENSE: sense_q <= wdat;
          OFF_BOTH:  both_q  <= wdat;
          OFF_EVT:   evt_q   <= wdat;
          OFF_IE:    ie_q    <= wdat;
          default:   ;
        endcase
      end
    end
  end

  assign clr_o = (wr_en && !data_win && addr_w == OFF_CLR) ? wdat : '0;
  assign mis_o = raw_i & ie_q;

  always_comb begin
    rd = '0;
    if (data_win) begin
      rd = ((dir_q & data_q) | (~dir_q & din_i)) & mask;
    end else begin
      unique case (addr_w)
        OFF_DIR:   rd = dir_q;
        OFF_SENSE: rd = sense_q;
        OFF_BOTH:  rd = both_q;
        OFF_EVT:   rd = evt_q;
        OFF_IE:    rd = ie_q;
        OFF_RIS:   rd = raw_i;
        OFF_MIS:   rd = mis_o;
        default:   rd = '0;
      endcase
    end
  end

  assign prdata_o = {{(BUS_W-PINS){1'b0}}, rd};
  assign dir_o    = dir_q;
  assign data_o   = data_q;
  assign sense_o  = sense_q;
  assign both_o   = both_q;
  assign evt_o    = evt_q;

  for (genvar g = 0; g < PINS; g++) begin : g_chk
    assert_input_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en && data_win && !dir_q[g]) |=> $stable(data_q[g]));
    assert_mask_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en && data_win && !mask[g]) |=> $stable(data_q[g]));
  end
endmodule

// File: rtl/mgpio_top.sv
module mgpio_top
  import mgpio_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [BUS_W-1:0]  pwdata_i,
  output logic [BUS_W-1:0]  prdata_o,
  input  logic [PINS-1:0]   pin_i,
  output logic [PINS-1:0]   pin_o,
  output logic [PINS-1:0]   pin_oe_o,
  output logic              irq_o
);
  logic [PINS-1:0] lvl, raw, dir, data, sense, both, evt, mis, clr;

  mgpio_sync #(.W(PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (lvl)
  );

  mgpio_regs #(.PINS(PINS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .psel_i   (psel_i),
    .penable_i(penable_i),
    .pwrite_i (pwrite_i),
    .paddr_i  (paddr_i),
    .pwdata_i (pwdata_i),
    .prdata_o (prdata_o),
    .din_i    (lvl),
    .raw_i    (raw),
    .dir_o    (dir),
    .data_o   (data),
    .sense_o  (sense),
    .both_o   (both),
    .evt_o    (evt),
    .mis_o    (mis),
    .clr_o    (clr)
  );

  mgpio_irq #(.PINS(PINS)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl),
    .sense_i(sense),
    .both_i (both),
    .evt_i  (evt),
    .clr_i  (clr),
    .raw_o  (raw)
  );

  assign pin_o    = data;
  assign pin_oe_o = dir;
  assign irq_o    = |mis;

  assert_irq_source_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (raw != '0));
  assert_irq_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw == '0) |-> !irq_o);
endmodule

// File: tb/mgpio_top_tb.sv
module mgpio_top_tb;
  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [7:0]  pin_i = '0;
  logic [7:0]  pin_o, pin_oe;
  logic        irq;

  int   n_chk = 0, n_err = 0;
  bit   done = 1'b0;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  mgpio_top u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .psel_i   (psel),
    .penable_i(penable),
    .pwrite_i (pwrite),
    .paddr_i  (paddr),
    .pwdata_i (pwdata),
    .prdata_o (prdata),
    .pin_i    (pin_i),
    .pin_o    (pin_o),
    .pin_oe_o (pin_oe),
    .irq_o    (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic exp_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  // monitor: compares each completed read against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (psel && penable && !pwrite) begin
        if (sb_q.size() == 0) begin
          chk("scoreboard underflow", 32'd1, 32'd0);
        end else begin
          exp_t it;
          it = sb_q.pop_front();
          chk(it.tag, prdata, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);

    // R1 reset state
    chk("R1 pin_oe", {24'd0, pin_oe}, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
    exp_rd(12'h400, 32'h0, "R1 dir");
    exp_rd(12'h404, 32'h0, "R1 sense");
    exp_rd(12'h410, 32'h0, "R1 ie");
    exp_rd(12'h414, 32'h0, "R1 ris");
    exp_rd(12'h3FC, 32'h0, "R1 data");

    // R6 / R4 input reads through synchronizer
    pin_i = 8'h3C;
    wait_n(4);
    exp_rd(12'h3FC, 32'h3C, "R6 input read");
    exp_rd(12'h030, 32'h0C, "R4 masked input read");

    // default config = falling edge
    pin_i = 8'h00;
    wait_n(4);
    exp_rd(12'h414, 32'h3C, "R8 default falling latch");
    bus_wr(12'h41C, 32'h0C);
    exp_rd(12'h414, 32'h30, "R11 clear ones");
    bus_wr(12'h41C, 32'h00);
    exp_rd(12'h414, 32'h30, "R11 clear zero no effect");
    bus_wr(12'h41C, 32'h30);
    exp_rd(12'h414, 32'h00, "R11 clear rest");

    // R13 decode
    bus_wr(12'h414, 32'hFF);
    exp_rd(12'h414, 32'h0, "R13 ris write ignored");
    exp_rd(12'h41C, 32'h0, "R13 clear reads zero");
    bus_wr(12'h420, 32'hFF);
    exp_rd(12'h420, 32'h0, "R13 unmapped reads zero");
    exp_rd(12'hFFC, 32'h0, "R13 top unmapped");
    exp_rd(12'h400, 32'h0, "R13 unmapped write no effect");

    // R2 direction
    bus_wr(12'h400, 32'hFF);
    chk("R2 pin_oe", {24'd0, pin_oe}, 32'hFF);
    exp_rd(12'h400, 32'hFF, "R2 dir readback");

    // R3 masked writes
    bus_wr(12'h3FC, 32'hA5);
    chk("R3 full write", {24'd0, pin_o}, 32'hA5);
    bus_wr(12'h004, 32'h00);
    chk("R3 single bit clear", {24'd0, pin_o}, 32'hA4);
    bus_wr(12'h044, 32'hFF);
    chk("R3 two bit set", {24'd0, pin_o}, 32'hB5);

    // R4 masked reads of outputs
    exp_rd(12'h3FC, 32'hB5, "R4 full read");
    exp_rd(12'h00C, 32'h01, "R4 partial read");
    exp_rd(12'h000, 32'h00, "R4 empty mask");

    // R5 input pins ignore data writes
    bus_wr(12'h400, 32'hF0);
    chk("R5 pin_oe", {24'd0, pin_oe}, 32'hF0);
    bus_wr(12'h3FC, 32'h00);
    chk("R5 input bits kept", {24'd0, pin_o}, 32'h05);
    exp_rd(12'h3FC, 32'h00, "R5 mixed read");
    bus_wr(12'h400, 32'hFF);
    chk("R5 kept after to-output", {24'd0, pin_o}, 32'h05);
    exp_rd(12'h3FC, 32'h05, "R5 read after to-output");

    // interrupt config: pin0 level high, pin1 level low, pin2 rise, pin3 fall, pin4 both
    bus_wr(12'h400, 32'h00);
    bus_wr(12'h40C, 32'h05);
    bus_wr(12'h408, 32'h10);
    bus_wr(12'h404, 32'h03);
    exp_rd(12'h414, 32'h02, "R7 level low active");
    exp_rd(12'h418, 32'h00, "R10 masked with ie=0");
    chk("R12 irq off when disabled", {31'd0, irq}, 32'h0);
    bus_wr(12'h410, 32'hFF);
    exp_rd(12'h418, 32'h02, "R10 masked with ie");
    chk("R12 irq on", {31'd0, irq}, 32'h1);
    bus_wr(12'h41C, 32'h02);
    exp_rd(12'h414, 32'h02, "R7 level not clearable");
    pin_i = 8'h02;
    wait_n(4);
    exp_rd(12'h414, 32'h00, "R7 level low released");
    chk("R12 irq off", {31'd0, irq}, 32'h0);
    pin_i = 8'h03;
    wait_n(4);
    exp_rd(12'h414, 32'h01, "R7 level high active");
    pin_i = 8'h02;
    wait_n(4);
    exp_rd(12'h414, 32'h00, "R7 level high released");

    // R8 rising
    pin_i = 8'h06;
    wait_n(4);
    exp_rd(12'h414, 32'h04, "R8 rising latched");
    pin_i = 8'h02;
    wait_n(4);
    exp_rd(12'h414, 32'h04, "R8 rising stays");
    bus_wr(12'h41C, 32'h04);
    exp_rd(12'h414, 32'h00, "R11 clear rising");

    // R8 falling
    pin_i = 8'h0A;
    wait_n(4);
    exp_rd(12'h414, 32'h00, "R8 falling ignores rise");
    pin_i = 8'h02;
    wait_n(4);
    exp_rd(12'h414, 32'h08, "R8 falling latched");
    bus_wr(12'h41C, 32'h08);

    // R9 both edges, event bit 0 ignored
    pin_i = 8'h12;
    wait_n(4);
    exp_rd(12'h414, 32'h10, "R9 rise latched");
    bus_wr(12'h41C, 32'h10);
    exp_rd(12'h414, 32'h00, "R9 cleared");
    pin_i = 8'h02;
    wait_n(4);
    exp_rd(12'h414, 32'h10, "R9 fall latched");
    bus_wr(12'h41C, 32'h10);
    exp_rd(12'h414, 32'h00, "R9 cleared again");
    chk("R12 irq idle", {31'd0, irq}, 32'h0);

    // R10 masking
    bus_wr(12'h410, 32'h01);
    pin_i = 8'h06;
    wait_n(4);
    exp_rd(12'h414, 32'h04, "R10 raw set");
    exp_rd(12'h418, 32'h00, "R10 masked off");
    chk("R12 irq masked", {31'd0, irq}, 32'h0);
    pin_i = 8'h07;
    wait_n(4);
    exp_rd(12'h418, 32'h01, "R10 masked level");
    chk("R12 irq from enabled", {31'd0, irq}, 32'h1);

    wait_n(3);
    chk("scoreboard drained", sb_q.size(), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule